// File: doc/BRIEF.md
# Prioritized Next-PC Selector

This block owns the fetch address register of an in-order pipeline. Every cycle it chooses the address that fetch uses next. The candidates are the sequential successor of the current address, a target from the branch predictor, the resolved target of a mispredicted branch, a replay address from either the execute or the memory stage, a trap handler base, and the saved exception PC used when a handler returns. Redirects raised by later stages win over the guesses made at fetch, and the block tells the younger stages when their work has to be discarded.

The block works out a mispredict on its own. The execute stage presents a resolved branch target together with the PC carried by the instruction that followed the branch. If the two differ, the wrong path was fetched. The chosen address is registered, and a fetch stall freezes it, except when a redirect arrives.

Top module: `npc_select`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `fetch_pc` equals the parameter `RESET_PC` and `flush` is 0.
- R2: With no redirect, no stall and `pred_taken` low, `fetch_pc` advances by `STEP` (default 4) at each clock edge, and `flush` is 0.
- R3: With no redirect, no stall and `pred_taken` high, the next `fetch_pc` is `pred_target`, and `flush` is 0.
- R4: A mispredict exists exactly when `br_valid` is high and `br_target` differs from `br_follow_pc`. With no higher-priority redirect, the next `fetch_pc` is then `br_target`. When the two are equal, the branch has no effect on the next `fetch_pc`.
- R5: A replay request loads the matching replay PC. When both replay requests are present, the memory-stage replay (`rep_m_pc`) wins over the execute-stage replay (`rep_x_pc`).
- R6: `trap_req` has the highest priority: the next `fetch_pc` is `trap_base` whatever else is requested.
- R7: `eret_req` without `trap_req` loads `eret_pc`, and it wins over both replays and a mispredict.
- R8: `flush` is high for exactly the one cycle after an edge at which a redirect (trap, trap return, replay or mispredict) was taken. It is low after every other edge.
- R9: `fetch_stall` without a redirect holds `fetch_pc` unchanged and ignores `pred_taken`. A redirect is taken even while `fetch_stall` is high.
- R10: The overall priority, from highest to lowest, is trap, trap return, memory replay, execute replay, mispredict, predicted taken, sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_stall | input | 1 | Fetch cannot advance this cycle |
| pred_taken | input | 1 | Predictor says the current fetch is a taken branch |
| pred_target | input | PC_W | Predicted target |
| br_valid | input | 1 | A branch resolved in the execute stage |
| br_target | input | PC_W | Resolved branch target |
| br_follow_pc | input | PC_W | PC of the instruction that followed the branch |
| rep_x_req | input | 1 | Replay request from the execute stage |
| rep_x_pc | input | PC_W | Execute-stage replay address |
| rep_m_req | input | 1 | Replay request from the memory stage |
| rep_m_pc | input | PC_W | Memory-stage replay address |
| trap_req | input | 1 | Trap or interrupt taken |
| trap_base | input | PC_W | Handler address |
| eret_req | input | 1 | Return from trap handler |
| eret_pc | input | PC_W | Saved exception PC |
| fetch_pc | output | PC_W | Registered next fetch address |
| flush | output | 1 | Younger stages must discard their contents |

## Verification
The hardest cases to reach are the ones where several redirects collide in the same cycle, in particular both replay requests together with a mispredict while fetch is stalled. Independent low-probability requests almost never produce that. The stimulus therefore mixes biased random cycles, where every request fires often enough that pairs and triples occur, with directed cycles that raise the whole set at once and then remove the winners one by one. A resolved branch whose target equals the follower PC is also forced on purpose, because random targets almost never match.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // Redirect slots in priority order, slot 0 is the highest.
    localparam int RD_TRAP = 0;
    localparam int RD_ERET = 1;
    localparam int RD_REPM = 2;
    localparam int RD_REPX = 3;
    localparam int RD_MISP = 4;
    localparam int RD_NUM  = 5;

    typedef enum logic [2:0] {
        SRC_SEQ,
        SRC_PRED,
        SRC_HOLD,
        SRC_MISP,
        SRC_REPX,
        SRC_REPM,
        SRC_ERET,
        SRC_TRAP
    } npc_src_e;

endpackage

// File: rtl/npc_misp_detect.sv
module npc_misp_detect #(
    parameter int PC_W = 32
) (
    input  logic            br_valid,
    input  logic [PC_W-1:0] br_target,
    input  logic [PC_W-1:0] br_follow_pc,
    output logic            misp
);
    // The wrong path was fetched when the follower's PC is not the real target.
    always_comb begin
        misp = br_valid && (br_target != br_follow_pc);
    end
endmodule

// File: rtl/npc_redirect_arb.sv
module npc_redirect_arb #(
    parameter int PC_W = 32,
    parameter int N    = 5
) (
    input  logic [N-1:0]           req,
    input  logic [N-1:0][PC_W-1:0] pc_in,
    output logic [N-1:0]           grant,
    output logic [PC_W-1:0]        pc_out,
    output logic                   any
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_slot
            if (i == 0) begin : g_top
                assign grant[i] = req[i];
            end else begin : g_lower
                assign grant[i] = req[i] & ~(|req[i-1:0]);
            end
        end
    endgenerate

    always_comb begin
        pc_out = '0;
        for (int k = 0; k < N; k++) begin
            pc_out = pc_out | (grant[k] ? pc_in[k] : '0);
        end
        any = |req;
    end
endmodule

// File: rtl/npc_seq_step.sv
module npc_seq_step #(
    parameter int PC_W = 32,
    parameter int STEP = 4
) (
    input  logic [PC_W-1:0] cur_pc,
    input  logic            pred_taken,
    input  logic [PC_W-1:0] pred_target,
    output logic [PC_W-1:0] step_pc,
    output logic            use_pred
);
    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    always_comb begin
        use_pred = pred_taken;
        step_pc  = pred_taken ? pred_target : (cur_pc + STEP_V);
    end
endmodule

// File: rtl/npc_select.sv
module npc_select #(
    parameter int              PC_W     = 32,
    parameter int              STEP     = 4,
    parameter logic [PC_W-1:0] RESET_PC = PC_W'(32'h0000_1000)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_stall,
    input  logic            pred_taken,
    input  logic [PC_W-1:0] pred_target,
    input  logic            br_valid,
    input  logic [PC_W-1:0] br_target,
    input  logic [PC_W-1:0] br_follow_pc,
    input  logic            rep_x_req,
    input  logic [PC_W-1:0] rep_x_pc,
    input  logic            rep_m_req,
    input  logic [PC_W-1:0] rep_m_pc,
    input  logic            trap_req,
    input  logic [PC_W-1:0] trap_base,
    input  logic            eret_req,
    input  logic [PC_W-1:0] eret_pc,
    output logic [PC_W-1:0] fetch_pc,
    output logic            flush
);
    import npc_pkg::*;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            flush;
    } npc_state_t;

    npc_state_t st_d, st_q;

    logic                        misp;
    logic [RD_NUM-1:0]           rd_req;
    logic [RD_NUM-1:0][PC_W-1:0] rd_pc;
    logic [RD_NUM-1:0]           rd_grant;
    logic [PC_W-1:0]             rd_sel_pc;
    logic                        rd_any;
    logic [PC_W-1:0]             step_pc;
    logic                        use_pred;
    npc_src_e                    src;

    npc_misp_detect #(.PC_W(PC_W)) misp_i (
        .br_valid     (br_valid),
        .br_target    (br_target),
        .br_follow_pc (br_follow_pc),
        .misp         (misp)
    );

    always_comb begin
        rd_req          = '0;
        rd_pc           = '0;
        rd_req[RD_TRAP] = trap_req;
        rd_pc[RD_TRAP]  = trap_base;
        rd_req[RD_ERET] = eret_req;
        rd_pc[RD_ERET]  = eret_pc;
        rd_req[RD_REPM] = rep_m_req;
        rd_pc[RD_REPM]  = rep_m_pc;
        rd_req[RD_REPX] = rep_x_req;
        rd_pc[RD_REPX]  = rep_x_pc;
        rd_req[RD_MISP] = misp;
        rd_pc[RD_MISP]  = br_target;
    end

    npc_redirect_arb #(.PC_W(PC_W), .N(RD_NUM)) arb_i (
        .req    (rd_req),
        .pc_in  (rd_pc),
        .grant  (rd_grant),
        .pc_out (rd_sel_pc),
        .any    (rd_any)
    );

    npc_seq_step #(.PC_W(PC_W), .STEP(STEP)) step_i (
        .cur_pc      (st_q.pc),
        .pred_taken  (pred_taken),
        .pred_target (pred_target),
        .step_pc     (step_pc),
        .use_pred    (use_pred)
    );

    // Next-state computation.
    always_comb begin
        st_d = st_q;
        if (rd_grant[RD_TRAP])      src = SRC_TRAP;
        else if (rd_grant[RD_ERET]) src = SRC_ERET;
        else if (rd_grant[RD_REPM]) src = SRC_REPM;
        else if (rd_grant[RD_REPX]) src = SRC_REPX;
        else if (rd_grant[RD_MISP]) src = SRC_MISP;
        else if (fetch_stall)       src = SRC_HOLD;
        else if (use_pred)          src = SRC_PRED;
        else                        src = SRC_SEQ;

        unique case (src)
            SRC_HOLD:          st_d.pc = st_q.pc;
            SRC_SEQ, SRC_PRED: st_d.pc = step_pc;
            default:           st_d.pc = rd_sel_pc;
        endcase
        st_d.flush = rd_any && !(src inside {SRC_SEQ, SRC_PRED, SRC_HOLD});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc    <= RESET_PC;
            st_q.flush <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc = st_q.pc;
    assign flush    = st_q.flush;

endmodule

// File: rtl/npc_select_checker.sv
module npc_select_checker #(
    parameter int PC_W = 32,
    parameter int STEP = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_stall,
    input logic            pred_taken,
    input logic [PC_W-1:0] pred_target,
    input logic            br_valid,
    input logic [PC_W-1:0] br_target,
    input logic [PC_W-1:0] br_follow_pc,
    input logic            rep_x_req,
    input logic            rep_m_req,
    input logic            trap_req,
    input logic [PC_W-1:0] trap_base,
    input logic            eret_req,
    input logic [PC_W-1:0] eret_pc,
    input logic [PC_W-1:0] fetch_pc,
    input logic            flush
);
    logic wrong_path;
    logic any_redirect;
    assign wrong_path   = br_valid && (br_target != br_follow_pc);
    assign any_redirect = trap_req || eret_req || rep_m_req || rep_x_req || wrong_path;

    assert_trap_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (fetch_pc == $past(trap_base)) && flush);

    assert_eret_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_req && !trap_req) |=> (fetch_pc == $past(eret_pc)));

    assert_misp_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrong_path && !trap_req && !eret_req && !rep_m_req && !rep_x_req)
        |=> (fetch_pc == $past(br_target)));

    assert_flush_only_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_redirect |=> !flush);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stall && !any_redirect) |=> $stable(fetch_pc));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stall && !any_redirect && !pred_taken)
        |=> (fetch_pc == $past(fetch_pc) + PC_W'(STEP)));

    assert_pred_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stall && !any_redirect && pred_taken)
        |=> (fetch_pc == $past(pred_target)));

endmodule

bind npc_select npc_select_checker #(.PC_W(PC_W), .STEP(STEP)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_stall  (fetch_stall),
    .pred_taken   (pred_taken),
    .pred_target  (pred_target),
    .br_valid     (br_valid),
    .br_target    (br_target),
    .br_follow_pc (br_follow_pc),
    .rep_x_req    (rep_x_req),
    .rep_m_req    (rep_m_req),
    .trap_req     (trap_req),
    .trap_base    (trap_base),
    .eret_req     (eret_req),
    .eret_pc      (eret_pc),
    .fetch_pc     (fetch_pc),
    .flush        (flush)
);

// File: tb/npc_select_tb_top.sv
module npc_select_tb_top;
    localparam logic [31:0] RST_PC = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_stall, pred_taken, br_valid, rep_x_req, rep_m_req, trap_req, eret_req;
    logic [31:0] pred_target, br_target, br_follow_pc, rep_x_pc, rep_m_pc, trap_base, eret_pc;
    logic [31:0] fetch_pc;
    logic        flush;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [31:0] exp_pc;

    always #4 clk = ~clk;

    npc_select dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_stall(fetch_stall),
        .pred_taken(pred_taken), .pred_target(pred_target),
        .br_valid(br_valid), .br_target(br_target), .br_follow_pc(br_follow_pc),
        .rep_x_req(rep_x_req), .rep_x_pc(rep_x_pc),
        .rep_m_req(rep_m_req), .rep_m_pc(rep_m_pc),
        .trap_req(trap_req), .trap_base(trap_base),
        .eret_req(eret_req), .eret_pc(eret_pc),
        .fetch_pc(fetch_pc), .flush(flush)
    );

    task automatic check(input string tag, input logic [31:0] act_pc, input logic [31:0] want_pc,
                         input logic act_fl, input logic want_fl);
        n_checks++;
        if (act_pc !== want_pc || act_fl !== want_fl) begin
            n_fail++;
            $display("FAIL %s: pc=%h flush=%b expected pc=%h flush=%b",
                     tag, act_pc, act_fl, want_pc, want_fl);
        end
    endtask

    // Reference model, written from the requirement list.
    function automatic void model(input logic [31:0] cur, output logic [31:0] npc,
                                  output logic fl, output string tag);
        fl = 1'b1;
        if (trap_req)                                    begin npc = trap_base; tag = "R6"; end
        else if (eret_req)                               begin npc = eret_pc;   tag = "R7"; end
        else if (rep_m_req)                              begin npc = rep_m_pc;  tag = "R5"; end
        else if (rep_x_req)                              begin npc = rep_x_pc;  tag = "R5"; end
        else if (br_valid && br_target != br_follow_pc)  begin npc = br_target; tag = "R4"; end
        else begin
            fl = 1'b0;
            if (fetch_stall)     begin npc = cur;         tag = "R9"; end
            else if (pred_taken) begin npc = pred_target; tag = "R3"; end
            else                 begin npc = cur + 32'd4; tag = "R2"; end
        end
    endfunction

    task automatic idle_inputs();
        fetch_stall = 0; pred_taken = 0; br_valid = 0; rep_x_req = 0; rep_m_req = 0;
        trap_req = 0; eret_req = 0;
        pred_target = 32'h0000_2000; br_target = 32'h0000_3000; br_follow_pc = 32'h0000_3004;
        rep_x_pc = 32'h0000_4000; rep_m_pc = 32'h0000_5000;
        trap_base = 32'h0000_0100; eret_pc = 32'h0000_6000;
    endtask

    // Inputs are set before the call; one edge, checked at the following falling edge.
    task automatic step(input string extra);
        logic [31:0] npc;
        logic fl;
        string tag;
        model(exp_pc, npc, fl, tag);
        @(posedge clk);
        @(negedge clk);
        exp_pc = npc;
        check({tag, extra}, fetch_pc, npc, flush, fl);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: pc=%h flush=%b expected run to finish", fetch_pc, flush);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        repeat (3) @(negedge clk);
        check("R1 in reset", fetch_pc, RST_PC, flush, 1'b0);
        rst_n = 1;
        exp_pc = RST_PC;
        check("R1 after release", fetch_pc, RST_PC, flush, 1'b0);

        step(" sequential");
        step(" sequential again");
        pred_taken = 1; step(" predicted");
        pred_taken = 0;
        // R4: matching target means the right path was fetched
        br_valid = 1; br_target = 32'h0000_7000; br_follow_pc = 32'h0000_7000; step(" equal target");
        br_follow_pc = 32'h0000_7004; pred_taken = 1; step(" R10 misp over predict");
        br_valid = 0; pred_taken = 0; step(" R8 flush drops");
        // R5 memory replay beats execute replay
        rep_m_req = 1; rep_x_req = 1; step(" both replays");
        rep_m_req = 0; step(" execute replay");
        rep_x_req = 0;
        // R6 / R7 / R10 full collision, then peel off winners
        trap_req = 1; eret_req = 1; rep_m_req = 1; rep_x_req = 1; br_valid = 1;
        pred_taken = 1; fetch_stall = 1; step(" all at once");
        trap_req = 0; step(" eret over rest");
        eret_req = 0; step(" replay under stall");
        rep_m_req = 0; rep_x_req = 0; step(" misp under stall");
        br_valid = 0; step(" stall holds, predict ignored");
        step(" stall holds again");
        idle_inputs();
        step(" resume");

        for (int i = 0; i < 3000; i++) begin
            fetch_stall  = ($urandom % 4) == 0;
            pred_taken   = ($urandom % 3) == 0;
            br_valid     = ($urandom % 5) == 0;
            rep_x_req    = ($urandom % 7) == 0;
            rep_m_req    = ($urandom % 7) == 0;
            trap_req     = ($urandom % 11) == 0;
            eret_req     = ($urandom % 9) == 0;
            pred_target  = $urandom & 32'hFFFF_FFFC;
            br_target    = $urandom & 32'hFFFF_FFFC;
            br_follow_pc = (($urandom % 3) == 0) ? br_target : ($urandom & 32'hFFFF_FFFC);
            rep_x_pc     = $urandom & 32'hFFFF_FFFC;
            rep_m_pc     = $urandom & 32'hFFFF_FFFC;
            trap_base    = $urandom & 32'hFFFF_FFFC;
            eret_pc      = $urandom & 32'hFFFF_FFFC;
            step(" random R10");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule